// File: doc/BRIEF.md
# Packet Ingress Buffer for a Packet-Mode Cell Bus

This block sits behind the transmit side of a packet-mode cell bus. Each clock it samples a 16-bit data lane together with an enable, an end-of-packet marker and an error marker. The accepted words go into a small on-chip buffer. A packet becomes visible downstream only once its final word has been stored cleanly. A packet that closes with a qualified error is thrown away: the write pointer is pulled back to the slot where that packet began, so none of its words reach the output.

Two lane arrangements are supported, and a static strap input chooses between them. In narrow mode a single 16-bit port feeds the buffer, and the upper half of each stored word is zero. In wide mode two ports are joined into one 32-bit word. Port A carries the upper half, port A's enable and end-of-packet frame the transfer, and an error on either port aborts the packet.

The output is a plain valid/ready stream with a last flag. A space indicator tells the sender when no slot is free. A word that arrives anyway while the buffer is full spoils its packet, and that packet is then discarded.

Top module: `pkt_ingress`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `space_ok` is 1.
- R2: In narrow mode (`wide_mode` = 0) a word is taken on each rising edge with `a_en` = 1, and it is stored as {16'h0, `a_data`}. `b_data`, `b_eop` and `b_err` have no effect in this mode.
- R3: In wide mode (`wide_mode` = 1) a word is taken on each rising edge with `a_en` = 1, and it is stored as {`a_data`, `b_data`}, so port A fills bits 31:16 and port B fills bits 15:0.
- R4: `a_eop` closes a packet only on an edge where `a_en` = 1. With `a_en` = 0 it has no effect.
- R5: An error marker counts only on an edge where both `a_en` and `a_eop` are 1. At every other time it has no effect.
- R6: A packet whose closing word carries a counted error produces no output word. Packets before and after it are delivered unchanged.
- R7: In wide mode `b_eop` never closes a packet, and the error marker on the closing word is `a_err` OR `b_err`.
- R8: No word of a packet is offered on the output before its closing word is stored. `out_valid` can rise on the cycle after the edge that stored a good closing word.
- R9: Output words leave in arrival order, and `out_last` = 1 exactly on each packet's closing word.
- R10: `space_ok` is 0 exactly when the buffer holds 2^ADDR_W words, counting words that are delivered, pending or in a packet still being received. A word that arrives while `space_ok` = 0 causes its whole packet to be discarded, and later packets are unaffected.
- R11: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R12: `wide_mode` is sampled as a static strap. It is changed only while `rst_n` = 0, and after reset the new mode governs word forming and framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 0: one 16-bit port; 1: ports A and B joined into 32 bits |
| a_en | input | 1 | Port A transfer enable (also the word enable in wide mode) |
| a_data | input | LANE_W | Port A data lane |
| a_eop | input | 1 | Port A end-of-packet marker |
| a_err | input | 1 | Port A error marker |
| b_data | input | LANE_W | Port B data lane (wide mode low half) |
| b_eop | input | 1 | Port B end-of-packet marker (never frames) |
| b_err | input | 1 | Port B error marker (wide mode only) |
| space_ok | output | 1 | 1 while at least one buffer slot is free |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 2*LANE_W | Output word |
| out_last | output | 1 | Output word closes its packet |

## Verification
The hardest situation to reach is an overrun in the middle of a packet. It needs the buffer to be nearly full of committed but unread words exactly when a new packet starts, and random traffic with a willing consumer almost never gets there. The stimulus therefore stalls the consumer, commits one long good packet that leaves three free slots, and then sends a six-word packet that overruns. It follows this with a short packet that must still fit and be delivered once the consumer resumes. Long random runs in both modes, with a sometimes-busy consumer and markers sprinkled on cycles where they must be ignored, cover the rest.

// File: rtl/pkt_ingress_pkg.sv
package pkt_ingress_pkg;

  typedef enum logic {
    LANES_NARROW = 1'b0,
    LANES_WIDE   = 1'b1
  } lane_mode_e;

endpackage

// File: rtl/pkt_lane_merge.sv
module pkt_lane_merge
  import pkt_ingress_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  lane_mode_e          mode,
  input  logic                a_en,
  input  logic [LANE_W-1:0]   a_data,
  input  logic                a_eop,
  input  logic                a_err,
  input  logic [LANE_W-1:0]   b_data,
  input  logic                b_eop,
  input  logic                b_err,
  output logic                w_valid,
  output logic [WORD_W-1:0]   w_data,
  output logic                w_eop,
  output logic                w_err
);

  // Word forming: wide mode puts port A on top, narrow zero-fills.
  function automatic logic [WORD_W-1:0] merge_lanes(
    input lane_mode_e m, input logic [LANE_W-1:0] hi, input logic [LANE_W-1:0] lo);
    if (m == LANES_WIDE) return {hi, lo};
    return {{LANE_W{1'b0}}, hi};
  endfunction

  // Abort source: the joined port listens to both error pins.
  function automatic logic abort_pick(input lane_mode_e m, input logic ea, input logic eb);
    if (m == LANES_WIDE) return ea | eb;
    return ea;
  endfunction

  // Port B framing pin never delimits anything.
  logic unused_b_eop;
  assign unused_b_eop = b_eop;

  always_comb begin
    w_valid = a_en;
    w_data  = merge_lanes(mode, a_data, b_data);
    w_eop   = a_en & a_eop;
    w_err   = a_en & a_eop & abort_pick(mode, a_err, b_err);
  end

endmodule

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int ADDR_W = 4,
  parameter int ENTRY_W = 33,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [ENTRY_W-1:0] rd_entry
);

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_entry;
  end

  assign rd_entry = mem[rd_addr];

endmodule

// File: rtl/pkt_wr_ctrl.sv
module pkt_wr_ctrl #(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_valid,
  input  logic              w_eop,
  input  logic              w_err,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTR_W-1:0]  cmt_ptr,
  output logic              full,
  output logic              ev_commit,
  output logic              ev_discard,
  output logic              ev_overrun
);

  function automatic logic [PTR_W-1:0] ptr_used(input logic [PTR_W-1:0] head,
                                                input logic [PTR_W-1:0] tail);
    return head - tail;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  logic [PTR_W-1:0] wr_ptr;
  logic             drop_q;
  logic             ev_close;
  logic             spoiled;

  assign full       = ptr_used(wr_ptr, rd_ptr) == PTR_W'(DEPTH);
  assign ev_overrun = w_valid & full;
  assign wr_en      = w_valid & ~full & ~drop_q;
  assign wr_addr    = wr_ptr[ADDR_W-1:0];
  assign ev_close   = w_valid & w_eop;
  assign spoiled    = w_err | drop_q | ev_overrun;
  assign ev_discard = ev_close & spoiled;
  assign ev_commit  = ev_close & ~spoiled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      drop_q  <= 1'b0;
    end else if (ev_discard) begin
      wr_ptr  <= cmt_ptr;
      drop_q  <= 1'b0;
    end else if (ev_commit) begin
      wr_ptr  <= ptr_next(wr_ptr);
      cmt_ptr <= ptr_next(wr_ptr);
    end else begin
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      if (ev_overrun) drop_q <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_used(wr_ptr, rd_ptr) <= PTR_W'(DEPTH)); // R10
  AST_DISCARD_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard |=> (wr_ptr == $past(cmt_ptr))); // R6
  AST_COMMIT_ONLY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit |=> $stable(cmt_ptr)); // R8
  AST_OVERRUN_SPOILS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overrun && !ev_close) |=> !ev_commit); // R10

endmodule

// File: rtl/pkt_rd_port.sv
module pkt_rd_port #(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  cmt_ptr,
  input  logic              out_ready,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic              pop
);

  function automatic logic [PTR_W-1:0] ptr_used(input logic [PTR_W-1:0] head,
                                                input logic [PTR_W-1:0] tail);
    return head - tail;
  endfunction

  assign out_valid = rd_ptr != cmt_ptr;
  assign pop       = out_valid & out_ready;
  assign rd_addr   = rd_ptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_ptr <= '0;
    else if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
  end

  AST_READ_BEHIND_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_used(cmt_ptr, rd_ptr) <= PTR_W'(DEPTH)); // R8

endmodule

// File: rtl/pkt_ingress.sv
module pkt_ingress
  import pkt_ingress_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int ADDR_W = 4,
  localparam int WORD_W = 2 * LANE_W,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              a_en,
  input  logic [LANE_W-1:0] a_data,
  input  logic              a_eop,
  input  logic              a_err,
  input  logic [LANE_W-1:0] b_data,
  input  logic              b_eop,
  input  logic              b_err,
  output logic              space_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);

  lane_mode_e        mode;
  logic              w_valid, w_eop, w_err;
  logic [WORD_W-1:0] w_data;
  logic              wr_en, full;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PTR_W-1:0]  cmt_ptr, rd_ptr;
  logic              ev_commit, ev_discard, ev_overrun, pop;
  logic [WORD_W:0]   rd_entry;

  assign mode = lane_mode_e'(wide_mode);

  pkt_lane_merge #(.LANE_W(LANE_W)) u_merge (
    .mode(mode), .a_en(a_en), .a_data(a_data), .a_eop(a_eop), .a_err(a_err),
    .b_data(b_data), .b_eop(b_eop), .b_err(b_err),
    .w_valid(w_valid), .w_data(w_data), .w_eop(w_eop), .w_err(w_err)
  );

  pkt_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_eop(w_eop), .w_err(w_err),
    .rd_ptr(rd_ptr), .wr_en(wr_en), .wr_addr(wr_addr), .cmt_ptr(cmt_ptr),
    .full(full), .ev_commit(ev_commit), .ev_discard(ev_discard),
    .ev_overrun(ev_overrun)
  );

  pkt_store #(.ADDR_W(ADDR_W), .ENTRY_W(WORD_W + 1)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_entry({w_eop, w_data}),
    .rd_addr(rd_addr), .rd_entry(rd_entry)
  );

  pkt_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cmt_ptr(cmt_ptr), .out_ready(out_ready),
    .rd_ptr(rd_ptr), .rd_addr(rd_addr), .out_valid(out_valid), .pop(pop)
  );

  assign space_ok = ~full;
  assign out_last = rd_entry[WORD_W];
  assign out_data = rd_entry[WORD_W-1:0];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R11
  AST_RELEASE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(ev_commit)); // R8
  AST_MODE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(wide_mode)); // R12
  AST_DISCARD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_discard && !out_valid) |=> !out_valid); // R6
  AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |-> !space_ok); // R10

endmodule

// File: tb/tb_pkt_ingress.sv
module tb_pkt_ingress;

  localparam int LANE_W = 16;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wide_mode = 1'b0;
  logic              a_en = 1'b0, a_eop = 1'b0, a_err = 1'b0;
  logic              b_eop = 1'b0, b_err = 1'b0;
  logic [LANE_W-1:0] a_data = '0, b_data = '0;
  logic              space_ok, out_valid, out_last;
  logic              out_ready = 1'b0;
  logic [WORD_W-1:0] out_data;

  pkt_ingress #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .a_en(a_en), .a_data(a_data), .a_eop(a_eop), .a_err(a_err),
    .b_data(b_data), .b_eop(b_eop), .b_err(b_err),
    .space_ok(space_ok), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always #10 clk = ~clk;

  int          vectors = 0;
  int          miscmp  = 0;
  bit          done    = 1'b0;
  string       sect    = "reset";
  int          rdy_pct = 100;
  bit          wide_m  = 1'b0;
  bit          drop_m  = 1'b0;
  logic [WORD_W:0] exp_q[$];
  logic [WORD_W:0] pend_q[$];

  function automatic logic [WORD_W-1:0] form_word(bit wide, logic [LANE_W-1:0] a,
                                                  logic [LANE_W-1:0] b);
    return wide ? {a, b} : {{LANE_W{1'b0}}, a};
  endfunction

  function automatic bit abort_of(bit wide, bit ea, bit eb);
    return wide ? (ea || eb) : ea;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s (%s): actual %0h expected %0h", rq, sect, act, expv);
    end
  endtask

  task automatic step(input bit en, input bit eop, input bit ea, input bit eb,
                      input bit beop, input logic [LANE_W-1:0] ad,
                      input logic [LANE_W-1:0] bd);
    bit had, rdy, full_m;
    @(negedge clk);
    had = exp_q.size() != 0;
    chk(out_valid === had, "R8", 64'(out_valid), 64'(had));
    if (had) chk({out_last, out_data} === exp_q[0], "R9",
                 64'({out_last, out_data}), 64'(exp_q[0]));
    full_m = (pend_q.size() + exp_q.size()) == DEPTH;
    chk(space_ok === !full_m, "R10", 64'(space_ok), 64'(!full_m));
    rdy = ($urandom % 100) < rdy_pct;
    out_ready = rdy;
    a_en = en; a_eop = eop; a_err = ea; b_err = eb; b_eop = beop;
    a_data = ad; b_data = bd;
    if (had && rdy) void'(exp_q.pop_front());
    if (en) begin
      if (full_m) drop_m = 1'b1;
      else if (!drop_m) pend_q.push_back({eop, form_word(wide_m, ad, bd)});
      if (eop) begin
        if (!drop_m && !abort_of(wide_m, ea, eb))
          foreach (pend_q[i]) exp_q.push_back(pend_q[i]);
        pend_q.delete();
        drop_m = 1'b0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 16'h0, 16'h0);
  endtask

  task automatic send_pkt(input int len, input bit ea_end, input bit eb_end);
    for (int i = 0; i < len; i++)
      step(1, i == len - 1, (i == len - 1) ? ea_end : 1'b0,
           (i == len - 1) ? eb_end : 1'b0, 1'($urandom),
           16'($urandom), 16'($urandom));
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; wide_mode = m; wide_m = m;
    a_en = 0; a_eop = 0; a_err = 0; b_eop = 0; b_err = 0; out_ready = 0;
    exp_q.delete(); pend_q.delete(); drop_m = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'(0));
    chk(space_ok === 1'b1, "R1", 64'(space_ok), 64'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'(0));
    chk(space_ok === 1'b1, "R1", 64'(space_ok), 64'(1));
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      rdy_pct = (i % 400 < 200) ? 85 : 25;
      step(($urandom % 4) != 0, ($urandom % 6) == 0, ($urandom % 8) == 0,
           ($urandom % 8) == 0, 1'($urandom), 16'($urandom), 16'($urandom));
    end
    step(1, 1, 0, 0, 0, 16'h1234, 16'h5678);
  endtask

  initial begin
    #(20 * 150000);
    miscmp++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(0);

    sect = "R2 narrow words, port B ignored";
    rdy_pct = 100;
    step(1, 0, 0, 1, 1, 16'hA001, 16'hFFFF);
    step(1, 0, 0, 1, 1, 16'hA002, 16'h1111);
    step(1, 1, 0, 1, 1, 16'hA003, 16'h2222);
    idle(4);

    sect = "R4 R5 markers without qualifiers";
    step(1, 0, 0, 0, 0, 16'hB001, 16'h0);
    step(0, 1, 1, 0, 0, 16'hDEAD, 16'h0);
    step(1, 0, 1, 0, 0, 16'hB002, 16'h0);
    step(1, 1, 0, 0, 0, 16'hB003, 16'h0);
    idle(5);

    sect = "R6 aborted packet then good packet";
    send_pkt(3, 1, 0);
    send_pkt(2, 0, 0);
    idle(5);

    sect = "R9 R11 backpressure";
    rdy_pct = 30;
    send_pkt(4, 0, 0); send_pkt(1, 0, 0); send_pkt(3, 0, 0);
    idle(30);
    rdy_pct = 100; idle(10);

    sect = "R10 overrun mid-packet";
    rdy_pct = 0;
    send_pkt(DEPTH - 3, 0, 0);
    send_pkt(6, 0, 0);
    send_pkt(2, 0, 0);
    step(1, 1, 0, 0, 0, 16'hC0DE, 16'h0);
    idle(3);
    rdy_pct = 100; idle(DEPTH + 5);

    sect = "R2 R4 R5 R6 R9 R10 random narrow";
    rand_run(1500);
    rdy_pct = 100; idle(DEPTH + 5);

    do_reset(1);
    sect = "R3 R7 R12 wide framing";
    rdy_pct = 100;
    step(1, 0, 0, 0, 1, 16'h1111, 16'h2222);
    step(1, 0, 0, 0, 1, 16'h3333, 16'h4444);
    step(1, 1, 0, 0, 0, 16'h5555, 16'h6666);
    idle(4);
    send_pkt(3, 0, 1);
    send_pkt(2, 1, 0);
    send_pkt(2, 0, 0);
    idle(5);

    sect = "R3 R7 R10 R11 random wide";
    rand_run(1500);
    rdy_pct = 100; idle(DEPTH + 5);

    sect = "R9 drained";
    @(negedge clk);
    chk(exp_q.size() == 0, "R9", 64'(exp_q.size()), 64'(0));
    chk(out_valid === 1'b0, "R9", 64'(out_valid), 64'(0));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule